// File: doc/BRIEF.md
# GPIO Runtime Port Register Bank

This block is the register bank that software touches at run time to drive and sample a 32-pin general purpose I/O unit. The pins are grouped into four 8-bit ports. A byte-wide I/O bus reaches the bank through a 16-byte window. The window starts at an address given on the `base_addr` input, which the configuration logic of the unit supplies. Each port has four byte registers: output data, input (pin level), event enable and event status. The ports start at irregular offsets in the window, and the last port overlaps the one before it.

Pin n belongs to port n>>3 at bit n&7. The output registers drive the pads directly. The pad inputs pass through a synchroniser before software can read them or the event logic can watch them. On the two lower ports, an enabled rising edge latches a sticky status bit. Software clears a status bit by writing 1 to it. The interrupt request stays high while any latched and enabled status bit exists. The two upper ports have no event hardware.

Top module: `gpio_rt_bank`

## Requirements
- R1: An access responds (`io_hit`=1) only when `io_addr - base_addr` (with `io_addr` >= `base_addr`) lies in 0..13. Offsets 14 and 15, and any address outside the window, give `io_hit`=0. Reads that do not hit return 0.
- R2: Ports 0, 1, 2 and 3 start at offsets 0, 4, 8 and 10. Inside a port, +0 is output, +1 is input, +2 is event enable and +3 is event status. At offsets 10 and 11, port 3 wins over port 2.
- R3: A write to an output register sets that port's byte of `pad_out`. Port p drives `pad_out[8p+7:8p]`. A read returns the last value written. `pad_out` changes only on such writes.
- R4: An input register returns the pad levels synchronised through two flops, so a change is readable two clock edges later. This holds whatever `pad_out` drives.
- R5: On ports 0 and 1, a rising edge of a synchronised pin whose enable bit is 1 sets the matching status bit. The bit stays set. Falling edges and edges on disabled pins set nothing.
- R6: Writing 1 to a status bit clears it. Status bits written with 0 keep their value.
- R7: `irq` is 1 exactly while some status bit of port 0 or 1 is 1 together with its enable bit. Clearing the enable drops `irq` but leaves the status bit readable as 1.
- R8: The event enable and status registers of ports 2 and 3 (port 3 at offsets 12 and 13) read as 0 and ignore writes.
- R9: While reset is active, and after it is released, every output register, enable and status register is 0, and `irq` is 0.
- R10: Changing `base_addr` moves the whole window. Register contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| base_addr | input | 16 | Start address of the 16-byte window |
| io_addr | input | 16 | Bus address |
| io_rd | input | 1 | Read strobe; read data is combinational |
| io_wr | input | 1 | Write strobe; takes effect at the clock edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data |
| io_hit | output | 1 | Address decodes to a register in the window |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output levels |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the bank with its default parameters: 16-bit addresses, 8-bit ports, two event-capable ports and a two-stage synchroniser. With these values the real irregular layout applies, so the overlap of port 3 onto port 2 and the unanswered offsets 14 and 15 can be reached. Both the event-capable and the event-less port variants are instantiated. The base address moves from 0x0300 to 0x1000, and out-of-window accesses just below and just above the window are checked.

// File: rtl/gpio_rt_pkg.sv
package gpio_rt_pkg;

  typedef enum logic [1:0] {
    REG_OUT  = 2'd0,
    REG_IN   = 2'd1,
    REG_EVEN = 2'd2,
    REG_EVST = 2'd3
  } reg_kind_e;

  localparam int NUM_PORTS = 4;
  localparam int WIN_BYTES = 16;
  localparam int WIN_W     = $clog2(WIN_BYTES);

  // Start offset of each port inside the window (irregular spacing).
  function automatic logic [WIN_W-1:0] port_start(input int p);
    case (p)
      0:       port_start = WIN_W'(0);
      1:       port_start = WIN_W'(4);
      2:       port_start = WIN_W'(8);
      default: port_start = WIN_W'(10);
    endcase
  endfunction

endpackage

// File: rtl/gpio_rt_decode.sv
module gpio_rt_decode
  import gpio_rt_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  output logic              hit,
  output logic [1:0]        port_sel,
  output reg_kind_e         kind
);

  logic [ADDR_W-1:0] off_full;
  logic              in_win;
  logic [WIN_W:0]    off;

  assign off_full = addr - base;
  assign in_win   = (addr >= base) && (off_full < ADDR_W'(WIN_BYTES));
  assign off      = {1'b0, off_full[WIN_W-1:0]};

  // Later ports override earlier ones: port 3 owns the overlap.
  always_comb begin
    hit      = 1'b0;
    port_sel = 2'd0;
    kind     = REG_OUT;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (off >= {1'b0, port_start(p)} &&
          off <  ({1'b0, port_start(p)} + (WIN_W+1)'(4))) begin
        hit      = in_win;
        port_sel = 2'(p);
        kind     = reg_kind_e'(off[1:0] - port_start(p)[1:0]);
      end
    end
  end

endmodule

// File: rtl/gpio_rt_port.sv
module gpio_rt_port #(
  parameter int PORT_W      = 8,
  parameter bit EVT_CAPABLE = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pad_in,
  input  logic              wr_out,
  input  logic              wr_en,
  input  logic              wr_st,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] out_q,
  output logic [PORT_W-1:0] in_q,
  output logic [PORT_W-1:0] en_q,
  output logic [PORT_W-1:0] st_q,
  output logic              irq_p
);

  logic [PORT_W-1:0] sync_q [SYNC_STAGES];
  logic [PORT_W-1:0] out_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= pad_in;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign in_q  = sync_q[SYNC_STAGES-1];
  assign out_d = wr_out ? wdata : out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  generate
    if (EVT_CAPABLE) begin : g_evt
      logic [PORT_W-1:0] prev_q, en_d, st_d, rise;

      assign rise = in_q & ~prev_q & en_q;
      assign en_d = wr_en ? wdata : en_q;
      // A new edge wins over a clear in the same cycle.
      assign st_d = (wr_st ? (st_q & ~wdata) : st_q) | rise;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= '0;
          en_q   <= '0;
          st_q   <= '0;
        end else begin
          prev_q <= in_q;
          en_q   <= en_d;
          st_q   <= st_d;
        end
      end
      assign irq_p = |(st_q & en_q);
    end else begin : g_noevt
      logic unused_evt;
      assign unused_evt = ^{wr_en, wr_st};
      assign en_q  = '0;
      assign st_q  = '0;
      assign irq_p = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/gpio_rt_bank.sv
module gpio_rt_bank
  import gpio_rt_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PORT_W      = 8,
  parameter int EVT_PORTS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           base_addr,
  input  logic [ADDR_W-1:0]           io_addr,
  input  logic                        io_rd,
  input  logic                        io_wr,
  input  logic [PORT_W-1:0]           io_wdata,
  output logic [PORT_W-1:0]           io_rdata,
  output logic                        io_hit,
  input  logic [NUM_PORTS*PORT_W-1:0] pad_in,
  output logic [NUM_PORTS*PORT_W-1:0] pad_out,
  output logic                        irq
);

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic [1:0]        port_sel;
  reg_kind_e         kind;
  logic [PORT_W-1:0] out_v [NUM_PORTS];
  logic [PORT_W-1:0] in_v  [NUM_PORTS];
  logic [PORT_W-1:0] en_v  [NUM_PORTS];
  logic [PORT_W-1:0] st_v  [NUM_PORTS];
  logic [NUM_PORTS-1:0] irq_v;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  gpio_rt_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (io_addr),
    .base     (base_addr),
    .hit      (io_hit),
    .port_sel (port_sel),
    .kind     (kind)
  );

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic sel;
      assign sel = io_wr && io_hit && (port_sel == 2'(p));

      gpio_rt_port #(
        .PORT_W      (PORT_W),
        .EVT_CAPABLE (p < EVT_PORTS),
        .SYNC_STAGES (SYNC_STAGES)
      ) u_port (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .pad_in (pad_in[p*PORT_W +: PORT_W]),
        .wr_out (sel && kind == REG_OUT),
        .wr_en  (sel && kind == REG_EVEN),
        .wr_st  (sel && kind == REG_EVST),
        .wdata  (io_wdata),
        .out_q  (out_v[p]),
        .in_q   (in_v[p]),
        .en_q   (en_v[p]),
        .st_q   (st_v[p]),
        .irq_p  (irq_v[p])
      );
      assign pad_out[p*PORT_W +: PORT_W] = out_v[p];
    end
  endgenerate

  always_comb begin
    io_rdata = '0;
    if (io_rd && io_hit) begin
      case (kind)
        REG_OUT:  io_rdata = out_v[port_sel];
        REG_IN:   io_rdata = in_v[port_sel];
        REG_EVEN: io_rdata = en_v[port_sel];
        default:  io_rdata = st_v[port_sel];
      endcase
    end
  end

  assign irq = |irq_v;

endmodule

// File: rtl/gpio_rt_bank_chk.sv
module gpio_rt_bank_chk #(
  parameter int ADDR_W = 16,
  parameter int PORT_W = 8,
  parameter int TOT_W  = 32
) (
  input logic              clk,
  input logic              rst_ok,
  input logic [ADDR_W-1:0] base_addr,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic [PORT_W-1:0] io_wdata,
  input logic [PORT_W-1:0] io_rdata,
  input logic              io_hit,
  input logic [TOT_W-1:0]  pad_out
);

  logic [ADDR_W-1:0] off_c;
  assign off_c = io_addr - base_addr;

  assert_no_hit_outside_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    (off_c >= ADDR_W'(14)) |-> !io_hit);

  assert_out_write_drives_pads_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (io_wr && io_hit && off_c == '0) |=> pad_out[PORT_W-1:0] == $past(io_wdata));

  assert_pads_hold_without_write_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    !io_wr |=> $stable(pad_out));

  assert_upper_evt_regs_zero_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (io_rd && io_hit && (off_c == ADDR_W'(12) || off_c == ADDR_W'(13))) |-> io_rdata == '0);

endmodule

bind gpio_rt_bank gpio_rt_bank_chk #(
  .ADDR_W (ADDR_W),
  .PORT_W (PORT_W),
  .TOT_W  (gpio_rt_pkg::NUM_PORTS*PORT_W)
) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .base_addr (base_addr),
  .io_addr   (io_addr),
  .io_rd     (io_rd),
  .io_wr     (io_wr),
  .io_wdata  (io_wdata),
  .io_rdata  (io_rdata),
  .io_hit    (io_hit),
  .pad_out   (pad_out)
);

// File: tb/gpio_rt_bank_bench.sv
module gpio_rt_bank_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] base_addr, io_addr;
  logic        io_rd, io_wr, io_hit, irq;
  logic [7:0]  io_wdata, io_rdata;
  logic [31:0] pad_in, pad_out;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_rt_bank u_gpio_rt_bank (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .io_addr(io_addr),
    .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_hit(io_hit), .pad_in(pad_in), .pad_out(pad_out), .irq(irq)
  );

  // {op (1=write), offset, wdata, expected hit, expected read data}
  localparam int NV = 19;
  localparam logic [31:0] VEC [NV] = '{
    {4'h1, 8'd0,  8'h55, 4'h1, 8'h00},
    {4'h0, 8'd0,  8'h00, 4'h1, 8'h55},
    {4'h1, 8'd4,  8'hAA, 4'h1, 8'h00},
    {4'h0, 8'd4,  8'h00, 4'h1, 8'hAA},
    {4'h1, 8'd8,  8'h0F, 4'h1, 8'h00},
    {4'h0, 8'd8,  8'h00, 4'h1, 8'h0F},
    {4'h1, 8'd10, 8'hF0, 4'h1, 8'h00},
    {4'h0, 8'd10, 8'h00, 4'h1, 8'hF0},
    {4'h0, 8'd1,  8'h00, 4'h1, 8'h81},
    {4'h0, 8'd5,  8'h00, 4'h1, 8'h0F},
    {4'h0, 8'd9,  8'h00, 4'h1, 8'h3C},
    {4'h0, 8'd11, 8'h00, 4'h1, 8'hA5},
    {4'h0, 8'd14, 8'h00, 4'h0, 8'h00},
    {4'h0, 8'd15, 8'h00, 4'h0, 8'h00},
    {4'h1, 8'd13, 8'hFF, 4'h1, 8'h00},
    {4'h0, 8'd13, 8'h00, 4'h1, 8'h00},
    {4'h1, 8'd12, 8'hFF, 4'h1, 8'h00},
    {4'h0, 8'd12, 8'h00, 4'h1, 8'h00},
    {4'h0, 8'd2,  8'h00, 4'h1, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input logic [15:0] addr, input logic [7:0] wd,
                     output logic hit, output logic [7:0] rd);
    @(negedge clk);
    io_addr = addr; io_wdata = wd; io_wr = wr; io_rd = !wr;
    #2;
    hit = io_hit; rd = io_rdata;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] off, input logic [7:0] exp);
    logic h; logic [7:0] d;
    acc(1'b0, base_addr + 16'(off), 8'h00, h, d);
    chk(req, {h, d}, {1'b1, exp});
  endtask

  task automatic wr_reg(input logic [3:0] off, input logic [7:0] wd);
    logic h; logic [7:0] d;
    acc(1'b1, base_addr + 16'(off), wd, h, d);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic h; logic [7:0] d;
    rst_n = 1'b0; base_addr = 16'h0300; io_addr = '0; io_rd = 0; io_wr = 0;
    io_wdata = '0; pad_in = 32'hA53C0F81;
    repeat (3) @(negedge clk);
    chk("R9 pad_out in reset", pad_out, 32'h0);
    chk("R9 irq in reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    settle();
    rd_chk("R9 out reg after reset", 4'd0, 8'h00);
    rd_chk("R9 status after reset", 4'd3, 8'h00);

    // Table walk: R1 R2 R3 R4 R8
    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][28], base_addr + 16'(VEC[i][27:20]), VEC[i][19:12], h, d);
      if (VEC[i][28]) chk($sformatf("R2 vec %0d hit", i), {31'b0, h}, {31'b0, VEC[i][8]});
      else chk($sformatf("R1 R2 R8 vec %0d", i), {h, d}, {VEC[i][8], VEC[i][7:0]});
    end
    chk("R3 pad_out bytes", pad_out, 32'hF00FAA55);
    chk("R4 irq idle", {31'b0, irq}, 32'h0);

    // R1: just outside the window
    acc(1'b0, 16'h02FF, 8'h00, h, d);
    chk("R1 below window", {h, d}, 9'h000);
    acc(1'b0, 16'h0310, 8'h00, h, d);
    chk("R1 above window", {h, d}, 9'h000);
    acc(1'b1, 16'h02FF, 8'h33, h, d);
    chk("R1 write below ignored", pad_out, 32'hF00FAA55);

    // R10: relocate window
    base_addr = 16'h1000;
    rd_chk("R10 relocated out reg", 4'd4, 8'hAA);
    acc(1'b0, 16'h0300, 8'h00, h, d);
    chk("R10 old base dead", {h, d}, 9'h000);

    // R5 R6 R7: port 0 bit 0 events
    wr_reg(4'd2, 8'h01);
    pad_in[0] = 1'b0; settle();
    rd_chk("R5 falling edge no status", 4'd3, 8'h00);
    pad_in[0] = 1'b1; settle();
    rd_chk("R5 rising edge sets status", 4'd3, 8'h01);
    chk("R7 irq set", {31'b0, irq}, 32'h1);
    pad_in[1] = 1'b1; settle();
    rd_chk("R5 disabled pin no status", 4'd3, 8'h01);
    wr_reg(4'd3, 8'h02);
    rd_chk("R6 write 0 keeps bit", 4'd3, 8'h01);
    wr_reg(4'd3, 8'h01);
    rd_chk("R6 write 1 clears", 4'd3, 8'h00);
    chk("R7 irq clear", {31'b0, irq}, 32'h0);
    pad_in[0] = 1'b0; settle(); pad_in[0] = 1'b1; settle();
    wr_reg(4'd2, 8'h00);
    #1 chk("R7 irq drops with enable", {31'b0, irq}, 32'h0);
    rd_chk("R7 status survives", 4'd3, 8'h01);

    // R5 R7: port 1 bit 7 (pin 15)
    wr_reg(4'd6, 8'h80);
    pad_in[15] = 1'b1; settle();
    rd_chk("R5 port1 status", 4'd7, 8'h80);
    chk("R7 irq from port1", {31'b0, irq}, 32'h1);
    rd_chk("R4 port1 input", 4'd5, 8'h8F);

    // R8: port 2/3 edges never raise irq
    wr_reg(4'd7, 8'h80);
    pad_in[31:16] = 16'h0000; settle(); pad_in[31:16] = 16'hFFFF; settle();
    chk("R8 upper ports no irq", {31'b0, irq}, 32'h0);
    rd_chk("R8 port3 status zero", 4'd13, 8'h00);

    finish_run();
  end

endmodule